// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block keeps the reservation state behind load-exclusive / store-exclusive atomic sequences for a small group of processing elements (PEs). Each PE sends one request per cycle. A request carries a valid strobe, a 3-bit operation code and a physical address. The block tells that PE whether a store-exclusive may complete. It also gives a write-enable qualifier, so a store-exclusive that fails never reaches memory.

Each PE has two single-state-bit machines, and each holds one granule tag. The local machine is changed only by the PE's own actions. The global machine is also cleared when another PE writes to the tracked granule. A store-exclusive passes only while both machines are armed on its granule. A load-exclusive from one PE never touches another PE's reservation. As a result, when several PEs contend for one granule, a PE fails only because another PE's write landed first. Addresses are compared on 64-byte granules (`GRAN_LG2` = 6), so address bits [5:0] are ignored.

Local monitor states: `LM_OPEN` (no reservation) and `LM_EXCL` (reservation held). Its transitions are:
- arm: `LM_OPEN`→`LM_EXCL` on its own load-exclusive.
- re-arm: `LM_EXCL`→`LM_EXCL`, taking the new tag, on a further load-exclusive.
- disarm: `LM_EXCL`→`LM_OPEN` on its own store-exclusive, clear-exclusive or exception.

Global monitor states: `GM_OPEN` and `GM_EXCL`. Its transitions are:
- arm and re-arm: on its own load-exclusive.
- drop: `GM_EXCL`→`GM_OPEN` on its own store-exclusive.
- snoop-kill: `GM_EXCL`→`GM_OPEN` when another PE writes to the tracked granule in the same cycle.

Top module: `excl_monitor`

## Requirements
- R1: A load-exclusive (op code 0) arms both monitors of the issuing PE with the granule of its address, address bits [31:6].
- R2: A store-exclusive (op code 1) passes only if both of the PE's monitors are armed with the store's granule. Address bits [5:0] take no part in the comparison.
- R3: One cycle after a store-exclusive request, `stex_done` is 1 for that PE and `stex_fail` is 0 on pass or 1 on fail. In every other cycle both are 0.
- R4: One cycle after a plain store (op code 2) or a passing store-exclusive, `wr_en` is 1 for that PE. It is 0 after a failing store-exclusive.
- R5: Every store-exclusive, whether it passes or fails, disarms both monitors of the issuing PE.
- R6: A plain store or a passing store-exclusive by a PE disarms the global monitor of every other PE that tracks the same granule. A PE's own plain store leaves its own reservation intact.
- R7: A load-exclusive by another PE to the same granule leaves an existing reservation intact.
- R8: A clear-exclusive (op code 3) or an exception (op code 4) disarms only the issuing PE's local monitor. Other PEs' reservations are unaffected.
- R9: Store-exclusives in the same cycle that would pass on one granule are resolved by fixed priority, lowest PE index first. Only that PE passes. Store-exclusives on different granules pass independently.
- R10: A store-exclusive fails if another PE issues a plain store to the same granule in the same cycle.
- R11: After reset all monitors are disarmed and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | NUM_PE | Request strobe per PE |
| req_op | input | NUM_PE*3 | Op code per PE: 0 load-excl, 1 store-excl, 2 store, 3 clear-excl, 4 exception |
| req_addr | input | NUM_PE*ADDR_W | Physical address per PE |
| stex_done | output | NUM_PE | Store-exclusive status valid, one cycle after request |
| stex_fail | output | NUM_PE | 1 = store-exclusive failed, 0 = passed |
| wr_en | output | NUM_PE | Write-enable qualifier for the memory write |

## Verification
Two things can land on one granule in the same cycle. The first is several store-exclusives racing for it. The second is a store-exclusive colliding with another PE's plain store, where one PE's write kills the others' reservations in the very cycle they try to complete. The bench provokes both cases by arming several PEs with load-exclusives and then issuing the competing requests together. A reference model built from the priority and snoop rules predicts each PE's status and write-enable, and a scoreboard compares that prediction with the output one cycle later. Follow-up store-exclusives then show which reservations survived the collision.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LDEX  = 3'd0,
        OP_STEX  = 3'd1,
        OP_STORE = 3'd2,
        OP_CLREX = 3'd3,
        OP_EXCPT = 3'd4
    } excl_op_e;
endpackage

// File: rtl/excl_local_mon.sv
module excl_local_mon #(
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             excl_o,
    output logic [TAG_W-1:0] tag_o
);
    typedef enum logic {LM_OPEN, LM_EXCL} lm_state_e;

    lm_state_e        state_q, state_d;
    logic [TAG_W-1:0] tag_q, tag_d;

    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        unique case (state_q)
            LM_OPEN: if (set_i) begin            // arm
                state_d = LM_EXCL;
                tag_d   = tag_i;
            end
            LM_EXCL: if (clr_i) begin            // disarm
                state_d = LM_OPEN;
            end else if (set_i) begin            // re-arm
                tag_d   = tag_i;
            end
            default: state_d = LM_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LM_OPEN;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
        end
    end

    assign excl_o = (state_q == LM_EXCL);
    assign tag_o  = tag_q;

    AST_LM_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_i && clr_i)); // R8
endmodule

// File: rtl/excl_global_mon.sv
module excl_global_mon #(
    parameter int NUM_PE = 4,
    parameter int TAG_W  = 26
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         set_i,
    input  logic                         drop_i,
    input  logic [TAG_W-1:0]             tag_i,
    input  logic [NUM_PE-1:0]            snoop_vld_i,
    input  logic [NUM_PE-1:0][TAG_W-1:0] snoop_tag_i,
    output logic                         excl_o,
    output logic [TAG_W-1:0]             tag_o
);
    typedef enum logic {GM_OPEN, GM_EXCL} gm_state_e;

    gm_state_e        state_q, own_state, state_d;
    logic [TAG_W-1:0] tag_q, tag_d;
    logic             snoop_hit;

    // Own request first: arm, re-arm or drop.
    always_comb begin
        own_state = state_q;
        tag_d     = tag_q;
        unique case (state_q)
            GM_OPEN: if (set_i) begin
                own_state = GM_EXCL;
                tag_d     = tag_i;
            end
            GM_EXCL: if (drop_i) begin
                own_state = GM_OPEN;
            end else if (set_i) begin
                tag_d     = tag_i;
            end
            default: own_state = GM_OPEN;
        endcase
    end

    // Then writes from other PEs to the tracked granule: snoop-kill.
    always_comb begin
        snoop_hit = 1'b0;
        for (int j = 0; j < NUM_PE; j++)
            if (snoop_vld_i[j] && snoop_tag_i[j] == tag_d) snoop_hit = 1'b1;
        state_d = (own_state == GM_EXCL && snoop_hit) ? GM_OPEN : own_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GM_OPEN;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
        end
    end

    assign excl_o = (state_q == GM_EXCL);
    assign tag_o  = tag_q;

    AST_GM_SNOOP_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (excl_o && !set_i && snoop_hit) |=> !excl_o); // R6
endmodule

// File: rtl/excl_arbiter.sv
module excl_arbiter #(
    parameter int NUM_PE = 4,
    parameter int TAG_W  = 26
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_PE-1:0]            cand_i,
    input  logic [NUM_PE-1:0]            plain_st_i,
    input  logic [NUM_PE-1:0][TAG_W-1:0] tag_i,
    output logic [NUM_PE-1:0]            win_o
);
    logic [NUM_PE-1:0] ok;

    always_comb begin
        for (int i = 0; i < NUM_PE; i++) begin
            ok[i] = cand_i[i];
            for (int j = 0; j < NUM_PE; j++)
                if (j != i && plain_st_i[j] && tag_i[j] == tag_i[i]) ok[i] = 1'b0;
        end
        for (int i = 0; i < NUM_PE; i++) begin
            win_o[i] = ok[i];
            for (int j = 0; j < i; j++)
                if (ok[j] && tag_i[j] == tag_i[i]) win_o[i] = 1'b0;
        end
    end

    AST_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ok) |-> (|win_o)); // R9
    AST_WIN_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (win_o & ~cand_i) == '0); // R2
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_mon_pkg::*;
#(
    parameter int NUM_PE   = 4,
    parameter int ADDR_W   = 32,
    parameter int GRAN_LG2 = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PE-1:0]        req_valid,
    input  logic [NUM_PE*OP_W-1:0]   req_op,
    input  logic [NUM_PE*ADDR_W-1:0] req_addr,
    output logic [NUM_PE-1:0]        stex_done,
    output logic [NUM_PE-1:0]        stex_fail,
    output logic [NUM_PE-1:0]        wr_en
);
    localparam int TAG_W = ADDR_W - GRAN_LG2;

    logic [NUM_PE-1:0][TAG_W-1:0] req_tag, lm_tag, gm_tag;
    logic [NUM_PE-1:0] is_ldex, is_stex, is_st, is_clr;
    logic [NUM_PE-1:0] lm_excl, gm_excl, cand, win, st_ev;

    for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
        logic [OP_W-1:0]   op_g;
        logic [NUM_PE-1:0] others;

        assign op_g       = req_op[g*OP_W +: OP_W];
        assign req_tag[g] = req_addr[g*ADDR_W+GRAN_LG2 +: TAG_W];
        assign is_ldex[g] = req_valid[g] && op_g == OP_LDEX;
        assign is_stex[g] = req_valid[g] && op_g == OP_STEX;
        assign is_st[g]   = req_valid[g] && op_g == OP_STORE;
        assign is_clr[g]  = req_valid[g] && (op_g == OP_CLREX || op_g == OP_EXCPT);
        assign cand[g]    = is_stex[g] && lm_excl[g] && gm_excl[g]
                            && lm_tag[g] == req_tag[g] && gm_tag[g] == req_tag[g];
        assign st_ev[g]   = is_st[g] || win[g];
        assign others     = st_ev & ~(NUM_PE'(1) << g);

        excl_local_mon #(.TAG_W(TAG_W)) i_lmon (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (is_ldex[g]),
            .clr_i  (is_stex[g] || is_clr[g]),
            .tag_i  (req_tag[g]),
            .excl_o (lm_excl[g]),
            .tag_o  (lm_tag[g])
        );

        excl_global_mon #(.NUM_PE(NUM_PE), .TAG_W(TAG_W)) i_gmon (
            .clk         (clk),
            .rst_n       (rst_n),
            .set_i       (is_ldex[g]),
            .drop_i      (is_stex[g]),
            .tag_i       (req_tag[g]),
            .snoop_vld_i (others),
            .snoop_tag_i (req_tag),
            .excl_o      (gm_excl[g]),
            .tag_o       (gm_tag[g])
        );

        AST_LDEX_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
            is_ldex[g] |=> lm_excl[g]); // R1
        AST_STEX_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
            is_stex[g] |=> (!lm_excl[g] && !gm_excl[g])); // R5
        AST_CLR_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
            is_clr[g] |=> !lm_excl[g]); // R8
        AST_PASS_NEEDS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
            (stex_done[g] && !stex_fail[g]) |-> $past(lm_excl[g] && gm_excl[g])); // R2
        AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (stex_done[g] && stex_fail[g]) |-> !wr_en[g]); // R4

        for (genvar h = g + 1; h < NUM_PE; h++) begin : g_pair
            AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
                (stex_done[g] && !stex_fail[g] && stex_done[h] && !stex_fail[h])
                |-> $past(req_tag[g] != req_tag[h])); // R9
        end
    end

    excl_arbiter #(.NUM_PE(NUM_PE), .TAG_W(TAG_W)) i_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_i     (cand),
        .plain_st_i (is_st),
        .tag_i      (req_tag),
        .win_o      (win)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stex_done <= '0;
            stex_fail <= '0;
            wr_en     <= '0;
        end else begin
            stex_done <= is_stex;
            stex_fail <= is_stex & ~win;
            wr_en     <= is_st | win;
        end
    end
endmodule

// File: tb/test_excl_monitor.sv
`timescale 1ns/1ps
module test_excl_monitor;
    localparam int NP = 4;
    localparam int AW = 32;
    localparam int GL = 6;
    localparam int TW = AW - GL;

    typedef struct {
        logic [NP-1:0] done;
        logic [NP-1:0] fail;
        logic [NP-1:0] wr;
        string         rq;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]    req_valid = '0;
    logic [NP*3-1:0]  req_op = '0;
    logic [NP*AW-1:0] req_addr = '0;
    logic [NP-1:0]    stex_done, stex_fail, wr_en;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;
    exp_t sb[$];

    // Stimulus staging and reference model.
    bit          v[NP];
    int          op[NP];
    logic [AW-1:0] ad[NP];
    bit          lm[NP], gm[NP];
    logic [TW-1:0] lmt[NP], gmt[NP];

    always #10 clk = ~clk;

    excl_monitor #(.NUM_PE(NP), .ADDR_W(AW), .GRAN_LG2(GL)) i_excl_monitor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .stex_done(stex_done), .stex_fail(stex_fail), .wr_en(wr_en)
    );

    function automatic logic [TW-1:0] tg(logic [AW-1:0] a);
        return a[AW-1:GL];
    endfunction

    task automatic req(int pe, int o, logic [AW-1:0] a);
        v[pe] = 1; op[pe] = o; ad[pe] = a;
    endtask

    task automatic step(string rq);
        exp_t e;
        bit cand[NP], win[NP], ev[NP];
        e.rq = rq; e.done = '0; e.fail = '0; e.wr = '0;
        for (int i = 0; i < NP; i++) begin
            cand[i] = v[i] && op[i] == 1 && lm[i] && gm[i]
                      && lmt[i] == tg(ad[i]) && gmt[i] == tg(ad[i]);
            for (int j = 0; j < NP; j++)
                if (j != i && v[j] && op[j] == 2 && tg(ad[j]) == tg(ad[i])) cand[i] = 0;
        end
        for (int i = 0; i < NP; i++) begin
            win[i] = cand[i];
            for (int j = 0; j < i; j++)
                if (cand[j] && tg(ad[j]) == tg(ad[i])) win[i] = 0;
            ev[i] = (v[i] && op[i] == 2) || win[i];
            e.done[i] = v[i] && op[i] == 1;
            e.fail[i] = e.done[i] && !win[i];
            e.wr[i]   = ev[i];
        end
        @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            req_valid[i]          = v[i];
            req_op[i*3 +: 3]      = 3'(op[i]);
            req_addr[i*AW +: AW]  = ad[i];
        end
        sb.push_back(e);
        for (int i = 0; i < NP; i++) begin
            if (v[i] && op[i] == 0) begin
                lm[i] = 1; lmt[i] = tg(ad[i]); gm[i] = 1; gmt[i] = tg(ad[i]);
            end else if (v[i] && op[i] == 1) begin
                lm[i] = 0; gm[i] = 0;
            end else if (v[i] && (op[i] == 3 || op[i] == 4)) begin
                lm[i] = 0;
            end
        end
        for (int i = 0; i < NP; i++)
            for (int j = 0; j < NP; j++)
                if (j != i && ev[j] && tg(ad[j]) == gmt[i]) gm[i] = 0;
        for (int i = 0; i < NP; i++) begin v[i] = 0; op[i] = 0; ad[i] = '0; end
    endtask

    // Monitor: pop one expectation per clock, compare off the edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            if (sb.size() > 0) begin
                e = sb.pop_front();
                #2;
                for (int i = 0; i < NP; i++) begin
                    vectors++;
                    if (stex_done[i] !== e.done[i] || stex_fail[i] !== e.fail[i]
                        || wr_en[i] !== e.wr[i]) begin
                        errors++;
                        $display("FAIL %s pe%0d: got done/fail/wr=%b%b%b exp %b%b%b", e.rq, i,
                                 stex_done[i], stex_fail[i], wr_en[i], e.done[i], e.fail[i], e.wr[i]);
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    localparam logic [AW-1:0] A = 32'h0000_1040;
    localparam logic [AW-1:0] B = 32'h0000_2080;

    initial begin
        for (int i = 0; i < NP; i++) begin
            v[i] = 0; op[i] = 0; ad[i] = '0; lm[i] = 0; gm[i] = 0; lmt[i] = '0; gmt[i] = '0;
        end
        repeat (3) @(negedge clk);
        vectors++;
        if (stex_done !== '0 || stex_fail !== '0 || wr_en !== '0) begin
            errors++;
            $display("FAIL R11 reset outputs %b%b%b exp 0", stex_done, stex_fail, wr_en);
        end
        rst_n = 1'b1;
        step("R11 idle");
        req(0, 1, A); step("R11 no reservation after reset");
        req(0, 0, A); step("R1 ldex");
        req(0, 1, A + 8); step("R2 R3 R4 pass, low bits ignored");
        req(0, 1, A); step("R5 second stex fails");
        req(1, 0, A); req(2, 0, A); step("R7 two ldex");
        req(1, 1, A); step("R7 pe1 survives other ldex");
        req(2, 1, A); step("R6 pe2 killed by pe1 write");
        req(0, 0, A); step("R2 arm A");
        req(0, 1, B); step("R2 other granule fails");
        req(3, 0, A); step("R6 arm pe3");
        req(3, 2, A); step("R4 R6 own store");
        req(3, 1, A); step("R6 own store keeps resv");
        req(0, 0, A); step("R6 arm pe0");
        req(1, 2, A + 4); step("R6 other store");
        req(0, 1, A); step("R6 killed by store");
        req(1, 0, A); req(2, 0, A); step("R8 arm");
        req(1, 3, A); req(3, 4, B); step("R8 clrex and exception");
        req(1, 1, A); req(2, 1, A); step("R8 clrex fails, other passes");
        for (int i = 0; i < NP; i++) req(i, 0, A);
        step("R9 arm all");
        for (int i = 0; i < NP; i++) req(i, 1, A);
        step("R9 lowest wins");
        req(1, 0, A); req(2, 0, A); req(3, 0, A); step("R9 arm three");
        req(2, 1, A); req(3, 1, A); step("R9 pe2 beats pe3");
        req(1, 1, A); step("R9 pe1 killed by pe2");
        req(0, 0, A); req(1, 0, B); step("R9 arm two granules");
        req(0, 1, A); req(1, 1, B); step("R9 distinct granules both pass");
        req(0, 0, A); req(1, 0, A); step("R10 arm");
        req(0, 1, A); req(1, 2, A); step("R10 collision with store");
        req(1, 1, A); step("R10 pe1 own store kept resv");
        req(2, 2, B); step("R4 plain store");
        step("R3 idle");
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule